// File: doc/BRIEF.md
# Round-Robin Context Scheduler

This block shares one command execution engine among four hardware contexts. Each context has its own command queue. The scheduler sees only whether each queue holds something, and it pops the queue of the context that currently owns the engine. Ownership lasts for a programmable number of cycles, called a slice. When the slice ends, or when the owner's queue runs dry, the block looks for the next context with work in rotating order. It then hands the engine over.

A handover is a two-step exchange with an external state-storage agent. First the outgoing context's state is written out under a save request. Then the incoming context's state is brought back under a restore request. The current-context output names the context each request concerns. It shows the outgoing context during the save and the incoming context during the restore. If no other context has work, the owner keeps the engine and a new slice starts with no exchange.

Top module: `ctx_sched`

## Requirements
- R1: While reset is held, and in the first cycle after it, the current context is 0, no queue is popped, and neither the save nor the restore request is raised.
- R2: In the issue phase, the pop strobe is raised only for the current context, only while that context's non-empty flag is high, and at most one pop bit is set in any cycle.
- R3: A slice of value S (S at least 1) gives the current context exactly S issue cycles, counted from the first issue cycle of the slice. If another context has work, the save request rises in the cycle after the last issue cycle.
- R4: When the current context's queue is empty in an issue cycle and another context has work, the save request rises in the next cycle, even if the slice has not ended.
- R5: The incoming context is the first context with work found by searching from current+1 upward, wrapping from 3 to 0, and never choosing the current context.
- R6: When a slice ends or the current queue is empty and no other context has work, no save or restore happens. The current context stays, and its slice restarts at full length.
- R7: The save request stays high, and the current context shows the outgoing context, until a cycle with the save acknowledge high. In the next cycle the restore request is high and the current context shows the incoming context.
- R8: The restore request stays high until a cycle with the restore acknowledge high. Issuing resumes in the next cycle with a fresh slice.
- R9: No pop strobe is raised while a save or restore request is high.
- R10: The slice value is read live from the slice input, and a value of zero behaves as a one-cycle slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctx_nonempty_i | input | 4 | Per-context queue holds at least one command |
| ctx_pop_o | output | 4 | Per-context pop strobe, one command per cycle |
| slice_len_i | input | 8 | Slice length in cycles, 0 treated as 1 |
| save_req_o | output | 1 | Request to save the outgoing context's state |
| save_ack_i | input | 1 | Save done, one-cycle pulse |
| restore_req_o | output | 1 | Request to restore the incoming context's state |
| restore_ack_i | input | 1 | Restore done, one-cycle pulse |
| cur_ctx_o | output | 2 | Context owning the engine, or being saved or restored |

## Verification
The assertions assume three things about the inputs. Each acknowledge arrives only while its own request is high. It lasts one cycle per request. A queue's non-empty flag drops only after that queue has been popped or drained. The bench keeps to these assumptions. It derives every acknowledge from the request it sees at the ports, after a random delay. It drives each non-empty flag from a per-context occupancy count. That count falls with each observed pop and refills at random. The stimulus phases vary the slice value, including zero, and the refill density. They include a phase where only one context is ever refilled, so early switches and sole-owner slice restarts both occur.

// File: rtl/ctx_sched_pkg.sv
package ctx_sched_pkg;
  typedef enum logic [1:0] {
    ST_ISSUE   = 2'd0,
    ST_SAVE    = 2'd1,
    ST_RESTORE = 2'd2
  } sched_state_e;
endpackage

// File: rtl/ctx_rr_pick.sv
module ctx_rr_pick #(
  parameter int N_CTX = 4,
  parameter int IDW   = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
  input  logic [IDW-1:0]   cur_i,
  input  logic [N_CTX-1:0] req_i,
  output logic             found_o,
  output logic [IDW-1:0]   next_o
);
  localparam int SW = IDW + 1;

  logic [N_CTX-1:0] rot;
  logic [IDW-1:0]   rot_id [N_CTX];

  // rot[g] holds the request of context cur+g (mod N_CTX)
  for (genvar g = 0; g < N_CTX; g++) begin : g_rot
    logic [SW-1:0] sum;
    assign sum       = SW'(cur_i) + SW'(g);
    assign rot_id[g] = (sum >= SW'(N_CTX)) ? IDW'(sum - SW'(N_CTX)) : IDW'(sum);
    assign rot[g]    = req_i[rot_id[g]];
  end

  always_comb begin
    found_o = 1'b0;
    next_o  = cur_i;
    for (int k = N_CTX - 1; k >= 1; k--) begin
      if (rot[k]) begin
        found_o = 1'b1;
        next_o  = rot_id[k];
      end
    end
  end
endmodule

// File: rtl/ctx_slice_timer.sv
module ctx_slice_timer #(
  parameter int SLICE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic               advance_i,
  input  logic [SLICE_W-1:0] slice_len_i,
  output logic               last_o
);
  localparam int CW = SLICE_W + 1;

  logic [SLICE_W-1:0] elapsed_q;
  logic [CW-1:0]      eff_len;

  assign eff_len = (slice_len_i == '0) ? CW'(1) : CW'(slice_len_i);
  assign last_o  = (CW'(elapsed_q) + CW'(1)) >= eff_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        elapsed_q <= '0;
    else if (restart_i) elapsed_q <= '0;
    else if (advance_i) elapsed_q <= elapsed_q + SLICE_W'(1);
  end

  assert_restart_advance_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(restart_i && advance_i));

  assert_advance_not_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_i |-> !last_o);
endmodule

// File: rtl/ctx_sched.sv
module ctx_sched
  import ctx_sched_pkg::*;
#(
  parameter int N_CTX   = 4,
  parameter int SLICE_W = 8,
  parameter int IDW     = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_CTX-1:0]   ctx_nonempty_i,
  output logic [N_CTX-1:0]   ctx_pop_o,
  input  logic [SLICE_W-1:0] slice_len_i,
  output logic               save_req_o,
  input  logic               save_ack_i,
  output logic               restore_req_o,
  input  logic               restore_ack_i,
  output logic [IDW-1:0]     cur_ctx_o
);
  sched_state_e   state_q, state_d;
  logic [IDW-1:0] cur_q, cur_d;
  logic [IDW-1:0] next_q, next_d;

  logic           issuing, cur_has_work, slice_last, want_switch;
  logic           other_found;
  logic [IDW-1:0] other_id;
  logic           tmr_restart, tmr_advance;

  assign issuing      = (state_q == ST_ISSUE);
  assign cur_has_work = ctx_nonempty_i[cur_q];
  assign want_switch  = issuing && (!cur_has_work || slice_last);

  ctx_rr_pick #(.N_CTX(N_CTX), .IDW(IDW)) u_pick (
    .cur_i   (cur_q),
    .req_i   (ctx_nonempty_i),
    .found_o (other_found),
    .next_o  (other_id)
  );

  // fresh slice on resume, or when the owner keeps the engine
  assign tmr_restart = (state_q == ST_RESTORE && restore_ack_i) || (want_switch && !other_found);
  assign tmr_advance = issuing && !want_switch;

  ctx_slice_timer #(.SLICE_W(SLICE_W)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (tmr_restart),
    .advance_i   (tmr_advance),
    .slice_len_i (slice_len_i),
    .last_o      (slice_last)
  );

  for (genvar g = 0; g < N_CTX; g++) begin : g_pop
    assign ctx_pop_o[g] = issuing && (cur_q == IDW'(g)) && ctx_nonempty_i[g];
  end

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    next_d  = next_q;
    unique case (state_q)
      ST_ISSUE: begin
        if (want_switch && other_found) begin
          state_d = ST_SAVE;
          next_d  = other_id;
        end
      end
      ST_SAVE: begin
        if (save_ack_i) begin
          state_d = ST_RESTORE;
          cur_d   = next_q;
        end
      end
      ST_RESTORE: begin
        if (restore_ack_i) state_d = ST_ISSUE;
      end
      default: state_d = ST_ISSUE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ISSUE;
      cur_q   <= '0;
      next_q  <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      next_q  <= next_d;
    end
  end

  assign save_req_o    = (state_q == ST_SAVE);
  assign restore_req_o = (state_q == ST_RESTORE);
  assign cur_ctx_o     = cur_q;

  assert_pop_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ctx_pop_o));

  assert_pop_needs_work_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctx_pop_o != '0) |-> ctx_nonempty_i[cur_ctx_o]);

  assert_no_pop_in_switch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_req_o || restore_req_o) |-> (ctx_pop_o == '0));

  assert_req_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(save_req_o && restore_req_o));

  assert_save_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_req_o && !save_ack_i) |=> (save_req_o && $stable(cur_ctx_o)));

  assert_save_to_restore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_req_o && save_ack_i) |=> restore_req_o);

  assert_restore_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_req_o && !restore_ack_i) |=> (restore_req_o && $stable(cur_ctx_o)));

  assert_resume_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_req_o && restore_ack_i) |=> (!save_req_o && !restore_req_o && $stable(cur_ctx_o)));

  assert_new_owner_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(restore_req_o) |-> (cur_ctx_o != $past(cur_ctx_o)));
endmodule

// File: tb/tb_ctx_sched.sv
module tb_ctx_sched;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int RUN_CYCLES = 8000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] nonempty = '0;
  logic [3:0] pop;
  logic [7:0] slice_len = 8'd4;
  logic       save_req, save_ack = 1'b0;
  logic       restore_req, restore_ack = 1'b0;
  logic [1:0] cur;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_sched dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctx_nonempty_i(nonempty), .ctx_pop_o(pop),
    .slice_len_i(slice_len),
    .save_req_o(save_req), .save_ack_i(save_ack),
    .restore_req_o(restore_req), .restore_ack_i(restore_ack),
    .cur_ctx_o(cur)
  );

  // reference model state
  int m_st = 0;   // 0 issue, 1 save, 2 restore
  int m_cur = 0;
  int m_nxt = 0;
  int m_cnt = 0;
  string m_why = "R1";
  int occ[N];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int ep;
    ep = (m_st == 0 && nonempty[m_cur]) ? (1 << m_cur) : 0;
    chk(int'(pop) == ep, (m_st == 0) ? "R2" : "R9", "pop", int'(pop), ep);
    chk(save_req == (m_st == 1), m_why, "save_req", int'(save_req), int'(m_st == 1));
    chk(restore_req == (m_st == 2), (m_st == 2) ? "R7" : "R8", "restore_req", int'(restore_req), int'(m_st == 2));
    chk(int'(cur) == m_cur, (m_st == 0) ? "R5" : "R7", "cur_ctx", int'(cur), m_cur);
  endtask

  task automatic model_step();
    int len;
    bit last, found;
    int nx;
    case (m_st)
      0: begin
        if (nonempty[m_cur]) occ[m_cur]--;
        len  = (slice_len == 0) ? 1 : int'(slice_len);
        last = (m_cnt + 1) >= len;
        if (!nonempty[m_cur] || last) begin
          found = 0; nx = 0;
          for (int k = 1; k < N; k++) begin
            if (!found && nonempty[(m_cur + k) % N]) begin found = 1; nx = (m_cur + k) % N; end
          end
          if (found) begin
            m_st = 1; m_nxt = nx;
            m_why = !nonempty[m_cur] ? "R4" : ((slice_len == 0) ? "R10" : "R3");
          end else begin
            m_cnt = 0; m_why = "R6";
          end
        end else begin
          m_cnt++; m_why = "R3";
        end
      end
      1: if (save_ack) begin m_st = 2; m_cur = m_nxt; m_why = "R7"; end
      default: if (restore_ack) begin m_st = 0; m_cnt = 0; m_why = "R8"; end
    endcase
  endtask

  task automatic drive(input int cyc);
    int mask, pct;
    if (cyc < 1500)      begin slice_len = 8'd4; mask = 4'hF; pct = 60; end
    else if (cyc < 3000) begin slice_len = 8'd0; mask = 4'hF; pct = 40; end
    else if (cyc < 4500) begin slice_len = 8'd7; mask = 4'hF; pct = 8;  end
    else if (cyc < 6000) begin slice_len = 8'd3; mask = 4'h4; pct = 50; end
    else begin slice_len = 8'(1 + (cyc / 97) % 6); mask = 4'hB; pct = 25; end
    for (int i = 0; i < N; i++) begin
      if (mask[i] && occ[i] < 12 && int'($urandom % 100) < pct) occ[i] += 1 + int'($urandom % 3);
      nonempty[i] = (occ[i] > 0);
    end
    save_ack    = save_req && ($urandom % 3 == 0);
    restore_ack = restore_req && ($urandom % 2 == 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) occ[i] = 0;
    repeat (3) @(negedge clk);
    chk(cur == 2'd0 && !save_req && !restore_req && pop == '0, "R1", "reset outputs",
        {26'd0, pop, cur} | (int'(save_req) << 6) | (int'(restore_req) << 7), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(cur == 2'd0 && !save_req && !restore_req && pop == '0, "R1", "first cycle",
        {26'd0, pop, cur} | (int'(save_req) << 6) | (int'(restore_req) << 7), 0);
    for (int cyc = 0; cyc < RUN_CYCLES && !done; cyc++) begin
      drive(cyc);
      #1;
      compare();
      @(posedge clk);
      model_step();
      @(negedge clk);
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R8 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule